// File: doc/BRIEF.md
# Configurable Programmable I/O Cell Bank

This block is a bank of identical pin cells. Each cell sits between one logic-fabric output net and one package pad. Each cell holds its own configuration word. The word sets the direction (input-only, output-only or bidirectional), the drive style (push-pull or open-drain), a slew flag, and the source of the output enable. The enable source is either the cell's own product-term enable, one of two global enables shared by the bank, or a permanent enable.

The configuration is captured per cell under a load mask and held until it is loaded again. The reset value puts every cell in input-only mode with push-pull style. The fabric data, the product-term enables and the two global enables are registered at the clock edge. The pad drive is then decoded from those registers.

The pad is a tri-state inout. The decoded drive enable and drive value also appear on their own ports, so the drive decision can be observed directly. The pad level is registered every cycle and returned to the routing fabric, whatever mode the cell is in.

Top module: `pio_cell_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every cell returns to its erased configuration: input-only, push-pull, slew flag 0, product-term enable source. A configuration load in that cycle is ignored. At the next sample point `drv_en_o`, `drv_val_o` and `slew_o` are all 0, and they stay 0 until a configuration is loaded.
- R2: A cell captures its fields at a clock edge only when its bit of `cfg_ld_i` is 1; otherwise it keeps its configuration. Field encodings: mode 2'b00 input-only, 2'b01 output-only, 2'b10 bidirectional, 2'b11 input-only; enable select 2'b00 product-term, 2'b01 global enable 0, 2'b10 global enable 1, 2'b11 always enabled; style bit 1 push-pull, 0 open-drain.
- R3: In input-only mode (codes 2'b00 and 2'b11) a cell never drives its pad, whatever the enable select, the enable inputs or the data.
- R4: In output-only mode a cell's driver is enabled whatever the enable select and the enable inputs. In open-drain style this still depends on the data, as R7 states.
- R5: In bidirectional mode the driver enable equals the enable source chosen by the select field.
- R6: In push-pull style an enabled cell drives its registered data value, either 1 or 0.
- R7: In open-drain style a cell drives only a low level. It is enabled only when its enable is active and its data is 0, and `drv_val_o` is always 0.
- R8: `drv_val_o` is 0 whenever `drv_en_o` is 0. The pad carries `drv_val_o` when `drv_en_o` is 1 and is high impedance otherwise.
- R9: `pad_in_o` presents the pad level one clock edge after it is sampled. This holds in every mode, including while the cell drives the pad.
- R10: `slew_o` shows each cell's configured slew flag and has no effect on `drv_en_o` or `drv_val_o`.
- R11: Data, product-term enables and global enables are sampled at a clock edge. The drive outputs change only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| goe0_i | input | 1 | Global output enable 0, shared by all cells |
| goe1_i | input | 1 | Global output enable 1, shared by all cells |
| core_data_i | input | N_CELLS | Fabric output value per cell |
| core_oe_i | input | N_CELLS | Product-term output enable per cell |
| cfg_ld_i | input | N_CELLS | Per-cell configuration load strobe |
| cfg_mode_i | input | 2*N_CELLS | Direction mode field, 2 bits per cell |
| cfg_totem_i | input | N_CELLS | Drive style bit per cell (1 push-pull, 0 open-drain) |
| cfg_slew_i | input | N_CELLS | Slew flag per cell |
| cfg_oesel_i | input | 2*N_CELLS | Enable source field, 2 bits per cell |
| pad_io | inout | N_CELLS | Package pads |
| drv_en_o | output | N_CELLS | Decoded driver enable per cell |
| drv_val_o | output | N_CELLS | Decoded driven value per cell |
| pad_in_o | output | N_CELLS | Registered pad level returned to the fabric |
| slew_o | output | N_CELLS | Configured slew flag per cell |

## Verification
The embedded properties check the following on every cycle:
- open-drain cells never drive a high level;
- a drive value never appears without an enable;
- input-only cells stay quiet;
- push-pull output-only cells always drive;
- the returned pad level matches what the cell drove one edge earlier;
- reset clears the drivers.

The bench scenarios are needed for the rest. They show that each enable-select code picks the right source, that unselected enables have no effect, and that the load mask leaves other cells untouched. They also show the input path when an external agent drives the pad, the one-edge sampling latency, and that the slew flag changes nothing in the drive outputs.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    PM_IN    = 2'b00,
    PM_OUT   = 2'b01,
    PM_BIDIR = 2'b10,
    PM_IN2   = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    OE_PT = 2'b00,
    OE_G0 = 2'b01,
    OE_G1 = 2'b10,
    OE_ON = 2'b11
  } oe_src_e;

  typedef struct packed {
    pin_mode_e mode;
    logic      totem;
    logic      slew;
    oe_src_e   oesel;
  } cell_cfg_t;

  localparam cell_cfg_t CFG_ERASED = '{mode: PM_IN, totem: 1'b1, slew: 1'b0, oesel: OE_PT};

endpackage

// File: rtl/pio_oe_mux.sv
module pio_oe_mux
  import pio_pkg::*;
(
  input  oe_src_e sel_i,
  input  logic    pt_oe_i,
  input  logic    goe0_i,
  input  logic    goe1_i,
  output logic    oe_o
);

  always_comb begin
    unique case (sel_i)
      OE_PT:   oe_o = pt_oe_i;
      OE_G0:   oe_o = goe0_i;
      OE_G1:   oe_o = goe1_i;
      default: oe_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/pio_drive.sv
module pio_drive
  import pio_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pin_mode_e mode_i,
  input  logic      totem_i,
  input  logic      oe_i,
  input  logic      data_i,
  output logic      en_o,
  output logic      val_o
);

  logic want;

  always_comb begin
    unique case (mode_i)
      PM_OUT:   want = 1'b1;
      PM_BIDIR: want = oe_i;
      default:  want = 1'b0;
    endcase
    if (totem_i) begin
      en_o  = want;
      val_o = want & data_i;
    end else begin
      en_o  = want & ~data_i;
      val_o = 1'b0;
    end
  end

  assert_od_low_only_R7: assert property (@(posedge clk) disable iff (rst)
    !totem_i |-> !val_o);

  assert_input_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PM_IN || mode_i == PM_IN2) |-> !en_o);

  assert_output_drives_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PM_OUT && totem_i) |-> en_o);

endmodule

// File: rtl/pio_rx.sv
module pio_rx (
  input  logic clk,
  input  logic rst,
  input  logic pad_i,
  output logic lvl_o
);

  always_ff @(posedge clk) begin
    if (rst) lvl_o <= 1'b0;
    else     lvl_o <= pad_i;
  end

endmodule

// File: rtl/pio_cell_bank.sv
module pio_cell_bank
  import pio_pkg::*;
#(
  parameter int N_CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 goe0_i,
  input  logic                 goe1_i,
  input  logic [N_CELLS-1:0]   core_data_i,
  input  logic [N_CELLS-1:0]   core_oe_i,
  input  logic [N_CELLS-1:0]   cfg_ld_i,
  input  logic [2*N_CELLS-1:0] cfg_mode_i,
  input  logic [N_CELLS-1:0]   cfg_totem_i,
  input  logic [N_CELLS-1:0]   cfg_slew_i,
  input  logic [2*N_CELLS-1:0] cfg_oesel_i,
  inout  wire  [N_CELLS-1:0]   pad_io,
  output logic [N_CELLS-1:0]   drv_en_o,
  output logic [N_CELLS-1:0]   drv_val_o,
  output logic [N_CELLS-1:0]   pad_in_o,
  output logic [N_CELLS-1:0]   slew_o
);

  localparam int FW = 2;

  logic goe0_q, goe1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      goe0_q <= 1'b0;
      goe1_q <= 1'b0;
    end else begin
      goe0_q <= goe0_i;
      goe1_q <= goe1_i;
    end
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    cell_cfg_t cfg_q;
    logic      data_q;
    logic      pt_q;
    logic      oe_sel;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q  <= CFG_ERASED;
        data_q <= 1'b0;
        pt_q   <= 1'b0;
      end else begin
        data_q <= core_data_i[i];
        pt_q   <= core_oe_i[i];
        if (cfg_ld_i[i]) begin
          cfg_q.mode  <= pin_mode_e'(cfg_mode_i[FW*i +: FW]);
          cfg_q.totem <= cfg_totem_i[i];
          cfg_q.slew  <= cfg_slew_i[i];
          cfg_q.oesel <= oe_src_e'(cfg_oesel_i[FW*i +: FW]);
        end
      end
    end

    pio_oe_mux u_oe (
      .sel_i   (cfg_q.oesel),
      .pt_oe_i (pt_q),
      .goe0_i  (goe0_q),
      .goe1_i  (goe1_q),
      .oe_o    (oe_sel)
    );

    pio_drive u_drv (
      .clk     (clk),
      .rst     (rst),
      .mode_i  (cfg_q.mode),
      .totem_i (cfg_q.totem),
      .oe_i    (oe_sel),
      .data_i  (data_q),
      .en_o    (drv_en_o[i]),
      .val_o   (drv_val_o[i])
    );

    assign pad_io[i] = drv_en_o[i] ? drv_val_o[i] : 1'bz;
    assign slew_o[i] = cfg_q.slew;

    pio_rx u_rx (
      .clk   (clk),
      .rst   (rst),
      .pad_i (pad_io[i]),
      .lvl_o (pad_in_o[i])
    );

    assert_val_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
      drv_val_o[i] |-> drv_en_o[i]);

    assert_rx_follows_drive_R9: assert property (@(posedge clk) disable iff (rst)
      drv_en_o[i] |=> (pad_in_o[i] == $past(drv_val_o[i])));

    assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!drv_en_o[i] && !slew_o[i]));
  end

endmodule

// File: tb/pio_cell_bank_tb.sv
module pio_cell_bank_tb;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         goe0, goe1;
  logic [N-1:0] data, ptoe, ld, totem, slew;
  logic [2*N-1:0] mode, oesel;
  logic [N-1:0] tb_en, tb_val;
  wire  [N-1:0] pad;
  logic [N-1:0] drv_en, drv_val, pad_in, slew_o;

  for (genvar i = 0; i < N; i++) begin : g_ext
    assign pad[i] = tb_en[i] ? tb_val[i] : 1'bz;
  end

  pio_cell_bank #(.N_CELLS(N)) u_dut (
    .clk(clk), .rst(rst), .goe0_i(goe0), .goe1_i(goe1),
    .core_data_i(data), .core_oe_i(ptoe), .cfg_ld_i(ld),
    .cfg_mode_i(mode), .cfg_totem_i(totem), .cfg_slew_i(slew),
    .cfg_oesel_i(oesel), .pad_io(pad), .drv_en_o(drv_en),
    .drv_val_o(drv_val), .pad_in_o(pad_in), .slew_o(slew_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Fields: [10:9] mode, [8] style, [7:6] oe select, [5] data, [4] pt oe,
  // [3] goe0, [2] goe1, [1] expected enable, [0] expected value
  localparam int NV = 16;
  localparam logic [10:0] VEC [NV] = '{
    11'b00_1_11_1111_00,  // R3 input-only
    11'b11_1_11_1111_00,  // R3 alternate input code
    11'b01_1_00_1000_11,  // R4 R6 output drives 1
    11'b01_1_00_0000_10,  // R4 R6 output drives 0
    11'b01_0_00_1000_00,  // R7 open-drain released
    11'b01_0_00_0000_10,  // R7 open-drain pulls low
    11'b10_1_00_1100_11,  // R5 pt enable on
    11'b10_1_00_1011_00,  // R5 pt off, globals ignored
    11'b10_1_01_1010_11,  // R5 goe0 selected
    11'b10_1_01_0101_00,  // R5 goe0 low, others ignored
    11'b10_1_10_0001_10,  // R5 goe1 selected
    11'b10_1_10_1110_00,  // R5 goe1 low
    11'b10_1_11_1000_11,  // R5 always enabled
    11'b10_0_11_1000_00,  // R7 bidir open-drain high
    11'b10_0_10_0001_10,  // R7 bidir open-drain low
    11'b10_0_10_0000_00   // R7 R8 disabled
  };

  task automatic set_cfg(input logic [1:0] m, input logic t, input logic s, input logic [1:0] o);
    mode  = {N{m}};
    totem = {N{t}};
    slew  = {N{s}};
    oesel = {N{o}};
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  initial begin
    goe0 = 0; goe1 = 0; data = '0; ptoe = '0; ld = '1;
    tb_en = '0; tb_val = '0;
    set_cfg(2'b01, 1'b1, 1'b1, 2'b11);
    data = '1;
    // R1: loads during reset are ignored
    tick; tick;
    chk("R1 en in reset", drv_en, 0);
    chk("R1 slew in reset", slew_o, 0);
    ld = '0;
    rst = 0;
    tick; tick;
    chk("R1 en after reset", drv_en, 0);
    chk("R1 val after reset", drv_val, 0);
    chk("R1 slew after reset", slew_o, 0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      ld = '1;
      set_cfg(VEC[k][10:9], VEC[k][8], 1'b0, VEC[k][7:6]);
      data = {N{VEC[k][5]}};
      ptoe = {N{VEC[k][4]}};
      goe0 = VEC[k][3];
      goe1 = VEC[k][2];
      tick;
      chk($sformatf("R2 R5 vec%0d en", k), drv_en, {N{VEC[k][1]}});
      chk($sformatf("R6 R7 R8 vec%0d val", k), drv_val, {N{VEC[k][0]}});
      tick;
      if (VEC[k][1]) chk($sformatf("R9 vec%0d pad_in", k), pad_in, {N{VEC[k][0]}});
    end

    // R2: load mask applies only to cell 0
    ld = '0; tick;
    set_cfg(2'b00, 1'b1, 1'b0, 2'b00);
    ld = '1; data = '1; tick;
    chk("R2 all input", drv_en, 0);
    set_cfg(2'b01, 1'b1, 1'b0, 2'b00);
    ld = 4'b0001; tick;
    chk("R2 masked load en", drv_en, 4'b0001);
    set_cfg(2'b00, 1'b1, 1'b0, 2'b00);
    ld = '0; tick;
    chk("R2 hold without load", drv_en, 4'b0001);

    // R9: external drive in input-only mode
    ld = '1; tick;
    ld = '0;
    tb_en = '1; tb_val = 4'b1010; tick;
    tick;
    chk("R9 pad_in 1010", pad_in, 4'b1010);
    tb_val = 4'b0101; tick; tick;
    chk("R9 pad_in 0101", pad_in, 4'b0101);
    tb_en = '0;

    // R10: slew flag only shows on status port
    set_cfg(2'b01, 1'b1, 1'b0, 2'b00);
    slew = 4'b0101;
    ld = '1; data = 4'b0110; tick;
    chk("R10 slew status", slew_o, 4'b0101);
    chk("R10 en unaffected", drv_en, 4'b1111);
    chk("R10 val unaffected", drv_val, 4'b0110);

    // R11: data sampled only at the edge
    ld = '0; data = 4'b1001;
    #1;
    chk("R11 before edge", drv_val, 4'b0110);
    tick;
    chk("R11 after edge", drv_val, 4'b1001);
    goe1 = 1'b1;
    set_cfg(2'b10, 1'b1, 1'b0, 2'b10);
    ld = '1; tick;
    ld = '0; goe1 = 1'b0;
    #1;
    chk("R11 goe before edge", drv_en, 4'b1111);
    tick;
    chk("R11 goe after edge", drv_en, 4'b0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule